// File: doc/BRIEF.md
# Rate-Multiplier PWM Channel with 12-Bit Resolution

This block produces one pulse-width-modulated output whose duty cycle is set by a 12-bit value. It does not compare against one 4096-step counter. A period instead consists of 16 equal subsections, each 256 ticks long. Every subsection carries the same basic pulse, whose high time is the upper eight bits of the value. The lower four bits drive a rate multiplier, which lengthens a chosen group of subsections by one tick each. Spreading the extra time this way moves the low-order duty energy to a higher frequency than a single long pulse would.

A tick lasts two clock cycles, so a whole period takes 8192 clocks. A new value is written with a one-cycle strobe. The value waits in a holding register and is applied only when the next period begins.

An output-control input and an active-low clear input both act at period boundaries. Either one can put the output into a disabled state, which models high impedance. While the output is disabled the level is held at 0. A clear also erases the stored value and stops the timebase. After a clear, the output stays disabled until a new value is written.

Top module: `rmpwm12`

## Requirements
- R1: After the asynchronous reset, `oe_o` and `pwm_o` are 0 and stay 0 until a value has been written and a period boundary has passed.
- R2: A tick is two clock cycles long and a period is 4096 ticks (8192 clocks). The period is divided into subsections 0 to 15 of 256 ticks (512 clocks) each, and the first period starts on the first clock after the internal reset is released.
- R3: In every subsection the output is high from the first tick until the tick count within the subsection reaches the effective width, and low after that. The base width is `duty_i[11:4]` ticks, and a width of 0 gives a constant low.
- R4: The rate multiplier adds one tick to the width of selected subsections. `duty_i[3]` selects odd subsection indices, `duty_i[2]` selects indices equal to 2 modulo 4, `duty_i[1]` selects indices equal to 4 modulo 8, and `duty_i[0]` selects index 8. Subsection 0 is never selected, so a low nibble of n lengthens exactly n subsections.
- R5: A value written during a period does not change that period. It is applied from the start of the next period.
- R6: `oe_o` changes only at a period boundary. It rises at the first boundary after a write, provided `oc_i` and `clr_n_i` allow it.
- R7: If `oc_i` is 1 at a period boundary, `oe_o` is 0 for the whole following period. If `oc_i` is 0 at a later boundary, `oe_o` returns to 1 with the previously stored value, without a new write.
- R8: If `clr_n_i` is 0 at a period boundary, the stored and pending values are cleared, `oe_o` goes to 0, and the timebase stops at subsection 0, tick 0 for as long as `clr_n_i` stays 0.
- R9: Writes are ignored while `clr_n_i` is 0 or while the timebase is stopped. After `clr_n_i` returns to 1, a new period starts on the next clock and `oe_o` stays 0 until a new write has been applied at a boundary.
- R10: `pwm_o` is 0 whenever `oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| duty_i | input | 12 | Duty value: bits 11:4 set the base width, bits 3:0 set the rate-multiplier count |
| load_i | input | 1 | One-cycle strobe that writes `duty_i` into the holding register |
| oc_i | input | 1 | Output control; 1 disables the output from the next period |
| clr_n_i | input | 1 | Active-low clear, applied at the end of the current period |
| pwm_o | output | 1 | PWM level, forced to 0 while disabled |
| oe_o | output | 1 | Output enable; 0 models high impedance |

## Verification
Some properties can be checked on every cycle, and the assertions cover these:
- the level is gated to 0 while the output is disabled;
- the enable changes only at a period boundary, and only rises right after one;
- the enable drops after a boundary at which output control is high or clear is low;
- the timebase stays stopped while clear is held and stays stopped after a clearing boundary;
- two boundaries never occur on back-to-back cycles.

Other properties can only be shown by the bench's scenarios, because they need whole periods:
- the high time of each of the 16 subsections, for a range of duty values;
- which subsections the rate multiplier lengthens;
- a write made in mid-period leaving the current period unchanged;
- a write being ignored while the timebase is stopped.

// File: rtl/rmpwm_pkg.sv
package rmpwm_pkg;

  // Run state of the period timebase
  typedef enum logic {
    TB_PARKED  = 1'b0,
    TB_RUNNING = 1'b1
  } tb_state_e;

endpackage

// File: rtl/rmpwm_timebase.sv
module rmpwm_timebase
  import rmpwm_pkg::*;
#(
  parameter int DIV_W = 1,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             period_end_o,
  output logic             running_o
);

  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  tb_state_e        st_q, st_d;
  logic             tick;

  assign running_o    = (st_q == TB_RUNNING);
  assign tick         = running_o && (&div_q);
  assign period_end_o = tick && (&pos_q);
  assign pos_o        = pos_q;

  always_comb begin
    div_d = div_q;
    pos_d = pos_q;
    st_d  = st_q;
    unique case (st_q)
      TB_RUNNING: begin
        div_d = div_q + 1'b1;
        if (tick) begin
          pos_d = pos_q + 1'b1;
        end
        if (period_end_o && !clr_n_i) begin
          st_d  = TB_PARKED;
          div_d = '0;
          pos_d = '0;
        end
      end
      TB_PARKED: begin
        div_d = '0;
        pos_d = '0;
        if (clr_n_i) begin
          st_d = TB_RUNNING;
        end
      end
      default: st_d = TB_PARKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pos_q <= '0;
      st_q  <= TB_RUNNING;
    end else begin
      div_q <= div_d;
      pos_q <= pos_d;
      st_q  <= st_d;
    end
  end

endmodule

// File: rtl/rmpwm_regs.sv
module rmpwm_regs #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] duty_i,
  input  logic              period_end_i,
  input  logic              running_i,
  input  logic              oc_i,
  input  logic              clr_n_i,
  output logic [DATA_W-1:0] act_o,
  output logic              oe_o
);

  logic [DATA_W-1:0] pend_q, pend_d;
  logic [DATA_W-1:0] act_q, act_d;
  logic              armed_q, armed_d;
  logic              oe_q, oe_d;
  logic              accept;

  // writes count only while the channel is not being cleared
  assign accept = load_i && clr_n_i && running_i;

  always_comb begin
    pend_d  = accept ? duty_i : pend_q;
    armed_d = armed_q | accept;
    act_d   = act_q;
    oe_d    = oe_q;
    if (period_end_i) begin
      if (!clr_n_i) begin
        pend_d  = '0;
        armed_d = 1'b0;
        act_d   = '0;
        oe_d    = 1'b0;
      end else begin
        act_d = pend_d;
        oe_d  = armed_d && !oc_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      act_q   <= '0;
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      act_q   <= act_d;
      armed_q <= armed_d;
      oe_q    <= oe_d;
    end
  end

  assign act_o = act_q;
  assign oe_o  = oe_q;

endmodule

// File: rtl/rmpwm_shaper.sv
module rmpwm_shaper #(
  parameter int SUB_W = 8,
  parameter int SEL_W = 4,
  localparam int CNT_W = SUB_W + SEL_W
) (
  input  logic [CNT_W-1:0] pos_i,
  input  logic [CNT_W-1:0] act_i,
  input  logic             oe_i,
  output logic             pwm_o
);

  logic [SEL_W-1:0] sub;
  logic [SUB_W-1:0] tk;
  logic [SUB_W-1:0] base;
  logic [SEL_W-1:0] frac;
  logic [SEL_W-1:0] hit;
  logic [SUB_W:0]   width;
  logic             level;

  assign sub  = pos_i[CNT_W-1:SUB_W];
  assign tk   = pos_i[SUB_W-1:0];
  assign base = act_i[CNT_W-1:SEL_W];
  assign frac = act_i[SEL_W-1:0];

  // bit-reversed rate multiplier: stage j matches indices whose lowest set bit is j
  for (genvar j = 0; j < SEL_W; j++) begin : g_rm
    localparam logic [SEL_W-1:0] PAT = SEL_W'(1) << j;
    localparam logic [SEL_W-1:0] MSK = (SEL_W'(1) << (j + 1)) - SEL_W'(1);
    assign hit[j] = frac[SEL_W-1-j] && ((sub & MSK) == PAT);
  end

  assign width = {1'b0, base} + {{SUB_W{1'b0}}, |hit};
  assign level = ({1'b0, tk} < width);
  assign pwm_o = oe_i && level;

endmodule

// File: rtl/rmpwm12.sv
module rmpwm12 #(
  parameter int SUB_W = 8,
  parameter int SEL_W = 4,
  parameter int DIV_W = 1,
  localparam int CNT_W = SUB_W + SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             load_i,
  input  logic             oc_i,
  input  logic             clr_n_i,
  output logic             pwm_o,
  output logic             oe_o
);

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] act;
  logic             period_end;
  logic             running;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  rmpwm_timebase #(
    .DIV_W(DIV_W),
    .CNT_W(CNT_W)
  ) u_tb (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .clr_n_i     (clr_n_i),
    .pos_o       (pos),
    .period_end_o(period_end),
    .running_o   (running)
  );

  rmpwm_regs #(
    .DATA_W(CNT_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .load_i      (load_i),
    .duty_i      (duty_i),
    .period_end_i(period_end),
    .running_i   (running),
    .oc_i        (oc_i),
    .clr_n_i     (clr_n_i),
    .act_o       (act),
    .oe_o        (oe_o)
  );

  rmpwm_shaper #(
    .SUB_W(SUB_W),
    .SEL_W(SEL_W)
  ) u_shp (
    .pos_i (pos),
    .act_i (act),
    .oe_i  (oe_o),
    .pwm_o (pwm_o)
  );

endmodule

// File: rtl/rmpwm12_chk.sv
module rmpwm12_chk (
  input logic clk,
  input logic rst_n,
  input logic oc_i,
  input logic clr_n_i,
  input logic period_end,
  input logic running,
  input logic pwm_o,
  input logic oe_o
);

  // R10
  level_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> !pwm_o);

  // R6
  oe_boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(oe_o));

  // R6
  oe_rise_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> $past(period_end));

  // R7
  oc_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && oc_i) |=> !oe_o);

  // R8
  clear_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !clr_n_i) |=> (!running && !oe_o));

  // R8
  park_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !clr_n_i) |=> !running);

  // R9
  parked_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !oe_o);

  // R2
  end_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !period_end);

endmodule

bind rmpwm12 rmpwm12_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .oc_i      (oc_i),
  .clr_n_i   (clr_n_i),
  .period_end(period_end),
  .running   (running),
  .pwm_o     (pwm_o),
  .oe_o      (oe_o)
);

// File: tb/rmpwm12_test.sv
module rmpwm12_test;

  localparam int PER_CLK = 8192;
  localparam int SUB_CLK = 512;
  localparam int ACT_AT  = 4000;
  localparam int NVEC    = 6;
  // {duty, expected high ticks per period}
  localparam logic [23:0] VEC [NVEC] = '{
    {12'h000, 12'd0},
    {12'h805, 12'd2053},
    {12'hFFF, 12'd4095},
    {12'h01A, 12'd26},
    {12'h00F, 12'd15},
    {12'h7F8, 12'd2040}
  };

  logic        clk;
  logic        rst_n;
  logic [11:0] duty_i;
  logic        load_i;
  logic        oc_i;
  logic        clr_n_i;
  logic        pwm_o;
  logic        oe_o;
  logic        realign;
  int          ci;
  int          checks;
  int          errors;
  int          cycles;

  rmpwm12 uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .duty_i (duty_i),
    .load_i (load_i),
    .oc_i   (oc_i),
    .clr_n_i(clr_n_i),
    .pwm_o  (pwm_o),
    .oe_o   (oe_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // bench clock index; 0 marks the first clock of a period
  always @(posedge clk) begin
    if (!rst_n) ci <= -2;
    else if (realign) ci <= 0;
    else ci <= ci + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected width in ticks of subsection s (R3, R4)
  function automatic int wid(input logic [11:0] d, input int s);
    int j;
    if (s == 0) return int'(d[11:4]);
    j = 0;
    while (((s >> j) & 1) == 0) j++;
    return int'(d[11:4]) + int'(d[3 - j]);
  endfunction

  // act: 0 none, 1 write nd, 2 oc high, 3 oc low, 4 clear low
  task automatic run_period(input logic [11:0] d, input bit en, input int exp_tot,
                            input string oe_req, input int act, input logic [11:0] nd);
    int hi [16];
    int bad [16];
    int oe_bad;
    int tot;
    oe_bad = 0;
    tot = 0;
    for (int s = 0; s < 16; s++) begin
      hi[s] = 0;
      bad[s] = 0;
    end
    for (int k = 0; k < PER_CLK; k++) begin
      int s;
      bit e;
      s = k / SUB_CLK;
      e = en && (((k % SUB_CLK) / 2) < wid(d, s));
      if (pwm_o) begin
        hi[s]++;
        tot++;
      end
      if (pwm_o !== e) bad[s]++;
      if (oe_o !== en) oe_bad++;
      if (k == ACT_AT) begin
        case (act)
          1: begin duty_i = nd; load_i = 1'b1; end
          2: oc_i = 1'b1;
          3: oc_i = 1'b0;
          4: clr_n_i = 1'b0;
          default: ;
        endcase
      end
      if (k == ACT_AT + 1) load_i = 1'b0;
      @(negedge clk);
    end
    chk(oe_bad == 0, oe_req, "enable level over period", oe_bad, 0);
    for (int s = 0; s < 16; s++) begin
      chk(bad[s] == 0, "R2/R3/R4/R10", $sformatf("subsection %0d high clocks", s),
          hi[s], en ? 2 * wid(d, s) : 0);
    end
    if (exp_tot >= 0) chk(tot == 2 * exp_tot, "R5", "high clocks per period", tot, 2 * exp_tot);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, 190000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    checks  = 0;
    errors  = 0;
    rst_n   = 1'b0;
    duty_i  = '0;
    load_i  = 1'b0;
    oc_i    = 1'b0;
    clr_n_i = 1'b1;
    realign = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(oe_o == 1'b0, "R1", "enable in reset", oe_o, 0);
    chk(pwm_o == 1'b0, "R1", "level in reset", pwm_o, 0);
    rst_n = 1'b1;
    do @(negedge clk); while (ci != 0);

    // R1: nothing written yet, so the first period stays disabled; write vector 0 in mid-period
    run_period(12'h000, 1'b0, -1, "R1", 1, VEC[0][23:12]);

    // table walk: each period shows the previous write (R5), next written mid-period
    for (int i = 0; i < NVEC; i++) begin
      run_period(VEC[i][23:12], 1'b1, int'(VEC[i][11:0]), "R6",
                 (i < NVEC - 1) ? 1 : 2,
                 (i < NVEC - 1) ? VEC[i + 1][23:12] : 12'h000);
    end

    // R7: output control took effect at the boundary; release it mid-period
    run_period(VEC[NVEC-1][23:12], 1'b0, 0, "R7", 3, 12'h000);
    // R7: enable returns with the stored value; clear asserted mid-period
    run_period(VEC[NVEC-1][23:12], 1'b1, int'(VEC[NVEC-1][11:0]), "R7", 4, 12'h000);

    // R8: timebase stopped, output disabled; R9: write while stopped is ignored
    begin
      int viol;
      viol = 0;
      for (int k = 0; k < 200; k++) begin
        if (oe_o !== 1'b0 || pwm_o !== 1'b0) viol++;
        if (k == 50) begin duty_i = 12'h800; load_i = 1'b1; end
        if (k == 51) load_i = 1'b0;
        @(negedge clk);
      end
      chk(viol == 0, "R8", "outputs while stopped", viol, 0);
    end
    clr_n_i = 1'b1;
    realign = 1'b1;
    @(negedge clk);
    realign = 1'b0;

    // R9: restart keeps output disabled; then a fresh write mid-period
    run_period(12'h000, 1'b0, 0, "R9", 1, 12'h123);
    // R9: the fresh write enables the output at the next boundary
    run_period(12'h123, 1'b1, 291, "R9", 0, 12'h000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule